// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit linear address into a physical address by reading a two-level page table in memory. It accepts one request at a time: the linear address, the access kind (read, write or instruction fetch), whether the access comes from user mode, the register that holds the base of the top-level table, and a switch that allows 4 MB pages. It then reads the directory entry and, for a 4 KB page, the table entry through a single word-wide memory port with a valid/ready handshake.

Along the way it writes the accessed flag back into each entry it uses and the dirty flag into the final entry on writes, but only when a flag actually goes from clear to set. It finishes with a one-cycle response. The response carries either the physical address and a small attribute vector, or a fault code. The fault code tells a missing entry from a rights violation and names the level where the walk stopped. It is meant to sit behind a translation cache and be started on a miss.

Top module: `pw_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `memValid` and `respValid` are 0.
- R2: The directory entry is read from `{dirBase[31:12],12'h000} + 4*linAddr[31:22]`. For a 4 KB page, the table entry is read next from `{pde[31:12],12'h000} + 4*linAddr[21:12]`.
- R3: An entry whose present flag (bit 0) is 0 ends the walk with a fault. `faultCode[1]` gives the level (0 directory, 1 table). `faultCode[0]` is 0 for not-present and 1 for a rights fault.
- R4: When the directory entry has its page-size flag (bit 7) set and `bigPageEn` is 1, the walk stops at that entry. The result is `physAddr = {pde[31:22], linAddr[21:0]}` with `pageAttr[0]` = 1.
- R5: When `bigPageEn` is 0, bit 7 of the directory entry has no effect. The walk reads the table entry and returns `{pte[31:12], linAddr[11:0]}` with `pageAttr[0]` = 0.
- R6: Every entry the walk uses ends up with its accessed flag (bit 5) set in memory. An entry is written only if one of its flags changes, so an entry whose flags are already set causes no memory write.
- R7: The dirty flag (bit 6) is set only in the final entry, and only for a write access (`accKind` = 1). A directory entry that points to a table never gets it.
- R8: A write when writable (bit 1) is 0, or a user-mode access when user (bit 2) is 0, gives a rights fault. For a 4 KB page these bits are the AND of both levels. The fault is reported at the level of the final entry, and that entry is not written.
- R9: While `memValid` is 1 and `memReady` is 0, `memValid`, `memWrite`, `memAddr` and `memWdata` hold steady.
- R10: `respValid` is a single-cycle pulse and `reqReady` is 1 only while idle. `pageAttr` is `{global(bit 8), cacheDisable(bit 4), writeThrough(bit 3), user, writable, largePage}`, with user and writable combined across levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken when reqReady is 1) |
| reqReady | output | 1 | Walker idle and able to take a request |
| linAddr | input | 32 | Linear address to translate |
| accKind | input | 2 | 0 read, 1 write, 2 fetch |
| userMode | input | 1 | Access made from user mode |
| dirBase | input | 32 | Top-level table base, bits 31:12 used |
| bigPageEn | input | 1 | Allow 4 MB pages at directory level |
| memValid | output | 1 | Memory access request |
| memReady | input | 1 | Memory accepts the access this cycle |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry value written back |
| memRdata | input | 32 | Read data, valid in the handshake cycle |
| respValid | output | 1 | One-cycle walk result |
| respFault | output | 1 | Result is a fault |
| faultCode | output | 2 | {level, rights} fault reason |
| physAddr | output | 32 | Translated address |
| pageAttr | output | 6 | Attribute vector of the translation |

## Verification
The rights check and the decision to write back the final entry's flags are made in the same cycle, the one in which that entry's read handshake completes. The bench provokes this with write and user-mode walks against entries whose writable or user bits are clear while their accessed and dirty flags are still clear, across random memory stalls. It judges the result by requiring the rights fault code and an unchanged final entry in the memory model. It also checks that the directory entry was still marked accessed when the fault came at table level.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int FRAME_W   = ADDR_W - OFF_W;
  localparam int BIG_W     = ADDR_W - BIG_OFF_W;
  localparam int ENT_SH    = 2;
  localparam int ATTR_W    = 6;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_WT    = 3;
  localparam int B_CD    = 4;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_SIZE  = 7;
  localparam int B_GLOB  = 8;

  localparam logic [1:0] ACC_WRITE = 2'd1;

  localparam logic [1:0] FC_DIR_NP   = 2'b00;
  localparam logic [1:0] FC_DIR_PROT = 2'b01;
  localparam logic [1:0] FC_TBL_NP   = 2'b10;
  localparam logic [1:0] FC_TBL_PROT = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_TBL, S_DONE, S_FAULT
  } walkState_e;

  typedef struct packed {
    logic       capReq;
    logic       capPde;
    logic       capPte;
    logic       memSelTbl;
    logic       faultSet;
    logic [1:0] faultCode;
  } ctlStrobe_t;

  typedef struct packed {
    logic present;
    logic bigHit;
    logic protOkDir;
    logic protOkTbl;
    logic dirNeedWb;
    logic tblNeedWb;
    logic leafBig;
  } dpStatus_t;
endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [ADDR_W-1:0]   reqLin,
  input  logic [1:0]          reqKind,
  input  logic                reqUser,
  input  logic [ADDR_W-1:0]   reqBase,
  input  logic                reqBigEn,
  input  logic [ADDR_W-1:0]   memRdata,
  output dpStatus_t           st,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   memWdata,
  output logic [ADDR_W-1:0]   physAddr,
  output logic [ATTR_W-1:0]   pageAttr,
  output logic [1:0]          faultCode
);
  localparam logic [ADDR_W-1:0] ACC_MASK   = ADDR_W'(1) << B_ACC;
  localparam logic [ADDR_W-1:0] DIRTY_MASK = ADDR_W'(1) << B_DIRTY;
  localparam int PAD_W = ADDR_W - IDX_W - ENT_SH;

  logic [ADDR_W-1:0]  linQ;
  logic [FRAME_W-1:0] baseQ;
  logic               isWrQ;
  logic               userQ;
  logic               bigEnQ;
  logic [ADDR_W-1:0]  pdeQ;
  logic [ADDR_W-1:0]  pteQ;
  logic               leafBigQ;
  logic [1:0]         faultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ     <= '0;
      baseQ    <= '0;
      isWrQ    <= 1'b0;
      userQ    <= 1'b0;
      bigEnQ   <= 1'b0;
      pdeQ     <= '0;
      pteQ     <= '0;
      leafBigQ <= 1'b0;
      faultQ   <= '0;
    end else begin
      if (ctl.capReq) begin
        linQ   <= reqLin;
        baseQ  <= reqBase[ADDR_W-1:OFF_W];
        isWrQ  <= (reqKind == ACC_WRITE);
        userQ  <= reqUser;
        bigEnQ <= reqBigEn;
      end
      if (ctl.capPde) begin
        pdeQ     <= memRdata;
        leafBigQ <= memRdata[B_SIZE] & bigEnQ;
      end
      if (ctl.capPte) pteQ <= memRdata;
      if (ctl.faultSet) faultQ <= ctl.faultCode;
    end
  end

  // Entry addresses for both levels
  logic [IDX_W-1:0]  dirIdx, tblIdx;
  logic [ADDR_W-1:0] dirAddr, tblAddr;
  assign dirIdx  = linQ[ADDR_W-1 -: IDX_W];
  assign tblIdx  = linQ[BIG_OFF_W-1 -: IDX_W];
  assign dirAddr = {baseQ, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, dirIdx, {ENT_SH{1'b0}}};
  assign tblAddr = {pdeQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tblIdx, {ENT_SH{1'b0}}};

  // Rights evaluation on live read data
  function automatic logic rightsOk(input logic canWr, input logic canUsr,
                                    input logic wantWr, input logic fromUsr);
    return !((wantWr && !canWr) || (fromUsr && !canUsr));
  endfunction

  logic liveBig;
  assign liveBig = memRdata[B_SIZE] & bigEnQ;

  always_comb begin
    st.present   = memRdata[B_PRES];
    st.bigHit    = liveBig;
    st.protOkDir = rightsOk(memRdata[B_WR], memRdata[B_USR], isWrQ, userQ);
    st.protOkTbl = rightsOk(pdeQ[B_WR] & memRdata[B_WR], pdeQ[B_USR] & memRdata[B_USR],
                            isWrQ, userQ);
    st.dirNeedWb = !memRdata[B_ACC] || (liveBig && isWrQ && !memRdata[B_DIRTY]);
    st.tblNeedWb = !memRdata[B_ACC] || (isWrQ && !memRdata[B_DIRTY]);
    st.leafBig   = leafBigQ;
  end

  // Write-back words: flags only ever get set
  logic [ADDR_W-1:0] dirWb, tblWb;
  assign dirWb = pdeQ | ACC_MASK | ((leafBigQ && isWrQ) ? DIRTY_MASK : '0);
  assign tblWb = pteQ | ACC_MASK | (isWrQ ? DIRTY_MASK : '0);

  assign memAddr  = ctl.memSelTbl ? tblAddr : dirAddr;
  assign memWdata = ctl.memSelTbl ? tblWb : dirWb;

  // Result formation
  always_comb begin
    if (leafBigQ) begin
      physAddr = {pdeQ[ADDR_W-1 -: BIG_W], linQ[BIG_OFF_W-1:0]};
      pageAttr = {pdeQ[B_GLOB], pdeQ[B_CD], pdeQ[B_WT], pdeQ[B_USR], pdeQ[B_WR], 1'b1};
    end else begin
      physAddr = {pteQ[ADDR_W-1:OFF_W], linQ[OFF_W-1:0]};
      pageAttr = {pteQ[B_GLOB], pteQ[B_CD], pteQ[B_WT],
                  pdeQ[B_USR] & pteQ[B_USR], pdeQ[B_WR] & pteQ[B_WR], 1'b0};
    end
  end

  assign faultCode = faultQ;
endmodule

// File: rtl/pw_control.sv
module pw_control
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memReady,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       reqReady,
  output logic       memValid,
  output logic       memWrite,
  output logic       respValid,
  output logic       respFault
);
  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    respValid = 1'b0;
    respFault = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capReq = 1'b1;
          nextState  = S_RD_DIR;
        end
      end
      S_RD_DIR: begin
        memValid = 1'b1;
        if (memReady) begin
          ctl.capPde = 1'b1;
          if (!st.present) begin
            ctl.faultSet  = 1'b1;
            ctl.faultCode = FC_DIR_NP;
            nextState     = S_FAULT;
          end else if (st.bigHit && !st.protOkDir) begin
            ctl.faultSet  = 1'b1;
            ctl.faultCode = FC_DIR_PROT;
            nextState     = S_FAULT;
          end else if (st.dirNeedWb) begin
            nextState = S_WB_DIR;
          end else if (st.bigHit) begin
            nextState = S_DONE;
          end else begin
            nextState = S_RD_TBL;
          end
        end
      end
      S_WB_DIR: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) nextState = st.leafBig ? S_DONE : S_RD_TBL;
      end
      S_RD_TBL: begin
        memValid      = 1'b1;
        ctl.memSelTbl = 1'b1;
        if (memReady) begin
          ctl.capPte = 1'b1;
          if (!st.present) begin
            ctl.faultSet  = 1'b1;
            ctl.faultCode = FC_TBL_NP;
            nextState     = S_FAULT;
          end else if (!st.protOkTbl) begin
            ctl.faultSet  = 1'b1;
            ctl.faultCode = FC_TBL_PROT;
            nextState     = S_FAULT;
          end else if (st.tblNeedWb) begin
            nextState = S_WB_TBL;
          end else begin
            nextState = S_DONE;
          end
        end
      end
      S_WB_TBL: begin
        memValid      = 1'b1;
        memWrite      = 1'b1;
        ctl.memSelTbl = 1'b1;
        if (memReady) nextState = S_DONE;
      end
      S_DONE: begin
        respValid = 1'b1;
        nextState = S_IDLE;
      end
      S_FAULT: begin
        respValid = 1'b1;
        respFault = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       linAddr,
  input  logic [1:0]        accKind,
  input  logic              userMode,
  input  logic [31:0]       dirBase,
  input  logic              bigPageEn,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              respValid,
  output logic              respFault,
  output logic [1:0]        faultCode,
  output logic [31:0]       physAddr,
  output logic [5:0]        pageAttr
);
  ctlStrobe_t ctl;
  dpStatus_t  st;

  pw_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady), .st(st),
    .ctl(ctl), .reqReady(reqReady), .memValid(memValid), .memWrite(memWrite),
    .respValid(respValid), .respFault(respFault)
  );

  pw_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqLin(linAddr), .reqKind(accKind),
    .reqUser(userMode), .reqBase(dirBase), .reqBigEn(bigPageEn), .memRdata(memRdata),
    .st(st), .memAddr(memAddr), .memWdata(memWdata), .physAddr(physAddr),
    .pageAttr(pageAttr), .faultCode(faultCode)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memValid,
  input logic        memWrite,
  input logic        memReady,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        respValid
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memWrite) && $stable(memAddr) && $stable(memWdata));

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid && !respValid);

  // R6
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |-> memWdata[5]);

  // R7
  wb_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid && memWrite) |-> $past(memValid && memReady && !memWrite));
endmodule

bind pw_walker pw_checker chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memValid(memValid),
  .memWrite(memWrite), .memReady(memReady), .memAddr(memAddr),
  .memWdata(memWdata), .respValid(respValid)
);

// File: tb/pw_walker_tb.sv
`timescale 1ns/1ps
module pw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] linAddr = '0;
  logic [1:0]  accKind = '0;
  logic        userMode = 1'b0;
  logic [31:0] dirBase = '0;
  logic        bigPageEn = 1'b0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        respValid;
  logic        respFault;
  logic [1:0]  faultCode;
  logic [31:0] physAddr;
  logic [5:0]  pageAttr;

  always #5 clk = ~clk;

  pw_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .linAddr(linAddr), .accKind(accKind), .userMode(userMode), .dirBase(dirBase),
    .bigPageEn(bigPageEn), .memValid(memValid), .memReady(memReady),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .respValid(respValid), .respFault(respFault),
    .faultCode(faultCode), .physAddr(physAddr), .pageAttr(pageAttr)
  );

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:4095];
  int nReads = 0;
  int nWrites = 0;
  logic [31:0] rdAddr0 = '0;
  logic [31:0] rdAddr1 = '0;
  bit stallPend = 1'b0;
  logic [31:0] stallAddr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  // Memory responder with random stalls; R9 hold checked at the port
  initial begin
    forever begin
      @(negedge clk);
      if (stallPend) begin
        chk(memValid === 1'b1 && memAddr === stallAddr, "R9", "request held during stall",
            memAddr, stallAddr);
      end
      stallPend = 1'b0;
      memReady = 1'b0;
      if (rstN && memValid) begin
        if ($urandom % 3 == 0) begin
          stallPend = 1'b1;
          stallAddr = memAddr;
        end else begin
          memReady = 1'b1;
          if (memWrite) begin
            mem[memAddr[13:2]] = memWdata;
            nWrites++;
          end else begin
            memRdata = mem[memAddr[13:2]];
            if (nReads == 0) rdAddr0 = memAddr;
            if (nReads == 1) rdAddr1 = memAddr;
            nReads++;
          end
        end
      end
    end
  end

  initial begin
    #(10 * 200000);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doWalk(input logic [31:0] lin, input logic [1:0] kind, input bit usr,
                        input logic [31:0] base, input bit bigEn);
    logic [31:0] pdeA, pde, newPde, pteA, pte, newPte, expPhys;
    logic [5:0]  expAttr;
    logic [1:0]  expCode;
    bit expFault, useTbl, isWr;
    int expWr, expRd, cyc;
    string tag;
    isWr = (kind == 2'd1);
    pdeA = {base[31:12], 12'h000} + {20'h0, lin[31:22], 2'b00};
    pde = mem[pdeA[13:2]];
    newPde = pde; pteA = '0; pte = '0; newPte = '0;
    expFault = 1'b0; expCode = 2'b00; useTbl = 1'b0; expPhys = '0; expAttr = '0;
    tag = "R6";
    if (!pde[0]) begin
      expFault = 1'b1; expCode = 2'b00; tag = "R3";
    end else if (pde[7] && bigEn) begin
      tag = "R4";
      if ((isWr && !pde[1]) || (usr && !pde[2])) begin
        expFault = 1'b1; expCode = 2'b01; tag = "R8";
      end else begin
        newPde = pde | 32'h20 | (isWr ? 32'h40 : 32'h0);
        expPhys = {pde[31:22], lin[21:0]};
        expAttr = {pde[8], pde[4], pde[3], pde[2], pde[1], 1'b1};
      end
    end else begin
      useTbl = 1'b1;
      if (pde[7]) tag = "R5";
      newPde = pde | 32'h20;
      pteA = {pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
      pte = mem[pteA[13:2]];
      newPte = pte;
      if (!pte[0]) begin
        expFault = 1'b1; expCode = 2'b10; tag = "R3";
      end else if ((isWr && !(pde[1] & pte[1])) || (usr && !(pde[2] & pte[2]))) begin
        expFault = 1'b1; expCode = 2'b11; tag = "R8";
      end else begin
        newPte = pte | 32'h20 | (isWr ? 32'h40 : 32'h0);
        expPhys = {pte[31:12], lin[11:0]};
        expAttr = {pte[8], pte[4], pte[3], pde[2] & pte[2], pde[1] & pte[1], 1'b0};
      end
    end
    expWr = int'(newPde != pde) + int'(useTbl && (newPte != pte));
    expRd = (pde[0]) ? 1 + int'(useTbl) : 1;

    @(negedge clk);
    nReads = 0; nWrites = 0;
    reqValid = 1'b1; linAddr = lin; accKind = kind; userMode = usr;
    dirBase = base; bigPageEn = bigEn;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R10", "busy after accept", 32'(reqReady), 32'h0);
    cyc = 0;
    while (respValid !== 1'b1 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(respValid === 1'b1, tag, "response arrived", 32'(respValid), 32'h1);
    chk(respFault === expFault, tag, "fault flag", 32'(respFault), 32'(expFault));
    if (expFault) begin
      chk(faultCode === expCode, tag, "fault code", 32'(faultCode), 32'(expCode));
    end else begin
      chk(physAddr === expPhys, tag, "physical address", physAddr, expPhys);
      chk(pageAttr === expAttr, "R10", "attributes", 32'(pageAttr), 32'(expAttr));
    end
    chk(rdAddr0 === pdeA, "R2", "directory entry address", rdAddr0, pdeA);
    if (useTbl)
      chk(rdAddr1 === pteA, "R2", "table entry address", rdAddr1, pteA);
    chk(nReads == expRd, "R2", "read count", 32'(nReads), 32'(expRd));
    chk(mem[pdeA[13:2]] === newPde, isWr ? "R7" : "R6", "directory entry in memory",
        mem[pdeA[13:2]], newPde);
    if (useTbl)
      chk(mem[pteA[13:2]] === newPte, expFault ? "R8" : (isWr ? "R7" : "R6"),
          "table entry in memory", mem[pteA[13:2]], newPte);
    chk(nWrites == expWr, "R6", "write-back count", 32'(nWrites), 32'(expWr));
    @(negedge clk);
    chk(respValid === 1'b0 && reqReady === 1'b1, "R10", "single response pulse",
        32'(respValid), 32'h0);
  endtask

  function automatic logic [31:0] randEntry(input bit dirLevel);
    logic [31:0] e;
    e = $urandom;
    e[0] = ($urandom % 8 != 0);
    if (dirLevel) e[13:12] = 2'(1 + ($urandom % 3));
    return e;
  endfunction

  initial begin
    void'($urandom(32'd42));
    for (int i = 0; i < 4096; i++) mem[i] = randEntry(i < 1024);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1", "reqReady in reset", 32'(reqReady), 32'h1);
    chk(memValid === 1'b0, "R1", "memValid in reset", 32'(memValid), 32'h0);
    chk(respValid === 1'b0, "R1", "respValid in reset", 32'(respValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: write via table, both entries need flags (R7)
    mem[5]  = 32'h0000_1007;
    mem[1024 + 7] = 32'hABCD_E117;
    doWalk({10'd5, 10'd7, 12'h345}, 2'd1, 1'b1, 32'h0, 1'b0);
    // Repeat: flags already set, no writes (R6)
    doWalk({10'd5, 10'd7, 12'h345}, 2'd1, 1'b1, 32'h0, 1'b0);
    // Large page read, flags already set (R4)
    mem[6] = 32'hFFC0_21E7;
    doWalk({10'd6, 22'h2A_BCDE}, 2'd0, 1'b0, 32'h0, 1'b1);
    // Large page write marks dirty in directory entry (R7)
    mem[9] = 32'h4000_2087;
    doWalk({10'd9, 22'h01_0203}, 2'd1, 1'b0, 32'h0, 1'b1);
    // Page-size bit ignored when disabled (R5)
    mem[10] = 32'h00C0_1083;
    mem[1024 + 3] = 32'h1234_5003;
    doWalk({10'd10, 10'd3, 12'hFFF}, 2'd2, 1'b0, 32'h0, 1'b0);
    // Write to a read-only directory level (R8)
    mem[11] = 32'h0000_2005;
    mem[2048 + 4] = 32'h5555_5007;
    doWalk({10'd11, 10'd4, 12'h000}, 2'd1, 1'b0, 32'h0, 1'b0);
    // User access to supervisor large page (R8)
    mem[12] = 32'h8000_0083;
    doWalk({10'd12, 22'h0}, 2'd0, 1'b1, 32'h0, 1'b1);
    // Missing table entry (R3)
    mem[13] = 32'h0000_3007;
    mem[3072 + 8] = 32'h7777_7006;
    doWalk({10'd13, 10'd8, 12'h010}, 2'd0, 1'b0, 32'h0, 1'b0);
    // Missing directory entry (R3)
    mem[14] = 32'hFFFF_F0FE;
    doWalk({10'd14, 10'd1, 12'h000}, 2'd1, 1'b1, 32'h0, 1'b1);

    // Constrained random walks
    for (int n = 0; n < 400; n++) begin
      logic [31:0] lin;
      logic [1:0]  kind;
      lin  = $urandom;
      kind = 2'($urandom % 3);
      if ($urandom % 2 == 0) begin
        mem[lin[31:22]] = randEntry(1'b1);
        mem[{mem[lin[31:22]][13:12], lin[21:12]}] = randEntry(1'b0);
      end
      doWalk(lin, kind, 1'($urandom % 2), $urandom & 32'hFFFF_C000, 1'($urandom % 2));
    end
    finishRun();
  end
endmodule